// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog

This block is a software watchdog that must be restarted by writing a two-value key to a byte-wide service register: first 0x55, then 0xAA. If firmware fails to complete that pair before the count runs out, the block emits a one-cycle reset request. The reset controller acts on it. The count advances only on cycles where the clock-enable tick input is high. An optional prescaler stretches every period by a power of two, and a 2-bit select chooses one of four timeout lengths.

Counting stops while low-power stop is active. It also stops while the debugger freeze input is high, but only when the freeze-stop control bit is set. A new timeout select is held in a shadow register. It becomes active only when the next key pair completes. The prescaler bit takes its reset value from a clock-mode strap input, and software can overwrite it later.

All reset behaviour is synchronous to `clk`. Period lengths are parameters: `BASE_EXP`, `STEP_EXP` and `PS_EXP`, with defaults 9, 2 and 9.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rst_req` is low. Reset clears the count, the pending-key flag and both the shadow and active timeout selects (select 0).
- R2: At reset the prescaler bit becomes 1 when `mode_strap` is 0 and 0 when `mode_strap` is 1. A control write (`ctl_we`) replaces it with `ctl_prescale` from the following cycle.
- R3: A service write of 0x55 followed later by a service write of 0xAA restarts the count from zero at the 0xAA write. Any number of idle cycles may separate the two writes.
- R4: A 0xAA write with no pending 0x55 is ignored. A service write of any value other than 0x55 or 0xAA drops a pending 0x55.
- R5: With the prescaler off, active select s gives a timeout of 2^(BASE_EXP+STEP_EXP*s) advances. With the defaults these are 2^9, 2^11, 2^13 and 2^15 for s = 0 to 3.
- R6: With the prescaler on, every period is multiplied by 2^PS_EXP. The default is 512, which gives 2^18 to 2^24.
- R7: A timeout select written through the control port has no effect on the running period until a key pair completes. From that restart on, the new select sets the period.
- R8: While `lp_stop` is high the count holds its value, without being cleared. Counting resumes on the first cycle after `lp_stop` falls.
- R9: While `freeze` and `frz_stop_en` are both high the count holds. `freeze` alone has no effect.
- R10: The count (and the prescaler) advances only on cycles where `tick` is high.
- R11: While `wd_enable` is low the count is held at zero and `rst_req` stays low. After re-enable, a full period elapses before the next request.
- R12: On expiry `rst_req` is high for exactly one cycle, the cycle after the final advance. The count reloads to zero and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Clock-mode strap, sampled during reset to set the prescaler bit |
| wd_enable | input | 1 | Watchdog enable |
| frz_stop_en | input | 1 | Control bit: halt counting while freeze is high |
| freeze | input | 1 | Debug freeze indication |
| lp_stop | input | 1 | Low-power stop active |
| tick | input | 1 | Clock enable for the count |
| svc_we | input | 1 | Service register write strobe |
| svc_data | input | KEY_W | Service register write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_prescale | input | 1 | Prescaler bit write value |
| ctl_tsel | input | SEL_W | Timeout select write value (shadowed) |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
None of the internal state is visible at the ports. A wrong pending-key flag, select, prescaler phase or count appears only as a reset request that arrives on the wrong cycle, or that never arrives. Such an error therefore shows up at the latest one timeout period after the fault. The bench's reference model predicts `rst_req` on every cycle, so the first misplaced pulse is caught on the exact cycle it happens. Directed gap measurements between pulses, and between a service and the following pulse, tie each miss to a requirement.

// File: rtl/wd_pkg.sv
package wd_pkg;
   localparam logic [7:0] DEF_KEY_OPEN  = 8'h55;
   localparam logic [7:0] DEF_KEY_CLOSE = 8'hAA;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;
endpackage

// File: rtl/wd_key_seq.sv
module wd_key_seq
   import wd_pkg::*;
#(
   parameter int KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_OPEN  = KEY_W'(DEF_KEY_OPEN),
   parameter logic [KEY_W-1:0] KEY_CLOSE = KEY_W'(DEF_KEY_CLOSE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [KEY_W-1:0] data,
   output logic             restart
);
   key_state_e state_q;

   // Restart is taken at the closing write itself.
   assign restart = we && (data == KEY_CLOSE) && (state_q == KEY_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KEY_IDLE;
      end else if (we) begin
         // Only the opening key arms; closing key and anything else disarm.
         state_q <= (data == KEY_OPEN) ? KEY_ARMED : KEY_IDLE;
      end
   end
endmodule

// File: rtl/wd_prescale.sv
module wd_prescale #(
   parameter int PS_EXP = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bypass,
   input  logic step_in,
   output logic step_out
);
   generate
      if (PS_EXP == 0) begin : g_none
         assign step_out = step_in;
      end else begin : g_div
         logic [PS_EXP-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (clr) begin
               div_q <= '0;
            end else if (step_in && !bypass) begin
               div_q <= div_q + 1'b1;
            end
         end

         assign step_out = step_in && (bypass || (&div_q));
      end
   endgenerate
endmodule

// File: rtl/wd_timebase.sv
module wd_timebase #(
   parameter int BASE_EXP = 9,
   parameter int STEP_EXP = 2,
   parameter int SEL_W    = 2,
   localparam int NSEL    = 1 << SEL_W,
   localparam int CNT_W   = BASE_EXP + STEP_EXP * (NSEL - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] lim_tab [NSEL];
   logic             at_lim;

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_lim
         assign lim_tab[g] = CNT_W'((64'd1 << (BASE_EXP + STEP_EXP * g)) - 64'd1);
      end
   endgenerate

   assign at_lim = (count_q == lim_tab[sel]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         expire  <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (clr) begin
            count_q <= '0;
         end else if (adv) begin
            if (at_lim) begin
               count_q <= '0;
               expire  <= 1'b1;
            end else begin
               count_q <= count_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wd_pkg::*;
#(
   parameter int KEY_W    = 8,
   parameter logic [KEY_W-1:0] KEY_OPEN  = KEY_W'(DEF_KEY_OPEN),
   parameter logic [KEY_W-1:0] KEY_CLOSE = KEY_W'(DEF_KEY_CLOSE),
   parameter int BASE_EXP = 9,
   parameter int STEP_EXP = 2,
   parameter int SEL_W    = 2,
   parameter int PS_EXP   = 9,
   localparam int CNT_W   = BASE_EXP + STEP_EXP * ((1 << SEL_W) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_strap,
   input  logic             wd_enable,
   input  logic             frz_stop_en,
   input  logic             freeze,
   input  logic             lp_stop,
   input  logic             tick,
   input  logic             svc_we,
   input  logic [KEY_W-1:0] svc_data,
   input  logic             ctl_we,
   input  logic             ctl_prescale,
   input  logic [SEL_W-1:0] ctl_tsel,
   output logic             rst_req
);
   generate
      if (BASE_EXP < 1)         begin : g_bad_base  $error("BASE_EXP must be at least 1");  end
      if (STEP_EXP < 0)         begin : g_bad_step  $error("STEP_EXP must not be negative"); end
      if (PS_EXP < 0)           begin : g_bad_ps    $error("PS_EXP must not be negative");   end
      if (CNT_W > 62)           begin : g_bad_cnt   $error("count width too large");        end
      if (KEY_OPEN == KEY_CLOSE) begin : g_bad_key  $error("keys must differ");             end
   endgenerate

   logic             presc_q;
   logic [SEL_W-1:0] tsel_shadow_q;
   logic [SEL_W-1:0] tsel_act_q;
   logic             restart;
   logic             run;
   logic             clr;
   logic             step;

   wd_key_seq #(
      .KEY_W    (KEY_W),
      .KEY_OPEN (KEY_OPEN),
      .KEY_CLOSE(KEY_CLOSE)
   ) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (svc_we),
      .data   (svc_data),
      .restart(restart)
   );

   // Control state: prescaler bit reset from strap, select shadowed until restart.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q       <= ~mode_strap;
         tsel_shadow_q <= '0;
         tsel_act_q    <= '0;
      end else begin
         if (ctl_we) begin
            presc_q       <= ctl_prescale;
            tsel_shadow_q <= ctl_tsel;
         end
         if (restart) begin
            tsel_act_q <= tsel_shadow_q;
         end
      end
   end

   assign run = wd_enable && tick && !lp_stop && !(freeze && frz_stop_en);
   assign clr = restart || !wd_enable;

   wd_prescale #(
      .PS_EXP(PS_EXP)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .bypass  (~presc_q),
      .step_in (run),
      .step_out(step)
   );

   wd_timebase #(
      .BASE_EXP(BASE_EXP),
      .STEP_EXP(STEP_EXP),
      .SEL_W   (SEL_W)
   ) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (step),
      .sel   (tsel_act_q),
      .expire(rst_req)
   );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
   parameter int CNT_W = 15,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wd_enable,
   input logic             lp_stop,
   input logic             freeze,
   input logic             frz_stop_en,
   input logic             restart,
   input logic             rst_req,
   input logic [CNT_W-1:0] count,
   input logic [SEL_W-1:0] tsel_act
);
   AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (count == '0)); // R3

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> $stable(tsel_act)); // R7

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_stop && wd_enable && !restart) |=> $stable(count)); // R8

   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && frz_stop_en && wd_enable && !restart) |=> $stable(count)); // R9

   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_enable |=> !rst_req); // R11

   AST_REQ_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (count == '0)); // R12

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R12
endmodule

bind keyed_watchdog wd_checker #(
   .CNT_W(CNT_W),
   .SEL_W(SEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wd_enable  (wd_enable),
   .lp_stop    (lp_stop),
   .freeze     (freeze),
   .frz_stop_en(frz_stop_en),
   .restart    (restart),
   .rst_req    (rst_req),
   .count      (u_time.count_q),
   .tsel_act   (tsel_act_q)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
   localparam int BASE_EXP = 4;
   localparam int STEP_EXP = 2;
   localparam int SEL_W    = 2;
   localparam int PS_EXP   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_strap = 1'b1;
   logic       wd_enable = 1'b0;
   logic       frz_stop_en = 1'b0;
   logic       freeze = 1'b0;
   logic       lp_stop = 1'b0;
   logic       tick = 1'b1;
   logic       svc_we = 1'b0;
   logic [7:0] svc_data = 8'h00;
   logic       ctl_we = 1'b0;
   logic       ctl_prescale = 1'b0;
   logic [1:0] ctl_tsel = 2'd0;
   logic       rst_req;

   always #2 clk = ~clk;

   keyed_watchdog #(
      .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .SEL_W(SEL_W), .PS_EXP(PS_EXP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .wd_enable(wd_enable),
      .frz_stop_en(frz_stop_en), .freeze(freeze), .lp_stop(lp_stop), .tick(tick),
      .svc_we(svc_we), .svc_data(svc_data), .ctl_we(ctl_we),
      .ctl_prescale(ctl_prescale), .ctl_tsel(ctl_tsel), .rst_req(rst_req)
   );

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural reference model
   int m_cnt = 0, m_pre = 0, m_act = 0, m_sh = 0, m_sh_old = 0;
   bit m_armed = 0, m_presc = 0, m_req = 0, m_hit = 0, m_run = 0, m_step = 0;

   function automatic int period_of(input int s);
      return 1 << (BASE_EXP + STEP_EXP * s);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_armed = 0; m_req = 0;
         m_act = 0; m_sh = 0; m_presc = !mode_strap;
      end else begin
         m_hit    = svc_we && (svc_data == 8'hAA) && m_armed;
         m_sh_old = m_sh;
         if (svc_we) m_armed = (svc_data == 8'h55);
         m_run = wd_enable && tick && !lp_stop && !(freeze && frz_stop_en);
         m_req = 0;
         if (m_hit || !wd_enable) begin
            m_cnt = 0; m_pre = 0;
            if (m_hit) m_act = m_sh_old;
         end else if (m_run) begin
            m_step = 1;
            if (m_presc) begin
               if (m_pre == (1 << PS_EXP) - 1) m_pre = 0;
               else begin m_pre++; m_step = 0; end
            end
            if (m_step) begin
               if (m_cnt == period_of(m_act) - 1) begin m_cnt = 0; m_req = 1; end
               else m_cnt++;
            end
         end
         if (ctl_we) begin m_presc = ctl_prescale; m_sh = ctl_tsel; end
      end
   end

   always @(negedge clk) begin
      check(rst_req === m_req, {cur_req, " per-cycle"}, int'(rst_req), int'(m_req));
   end

   // Directed stimulus helpers
   int cyc = 0, p_last = 0, p_prev = 0, npulse = 0;

   task automatic step();
      @(negedge clk);
      cyc++;
      if (rst_req) begin p_prev = p_last; p_last = cyc; npulse++; end
   endtask

   task automatic wait_pulse();
      int k = npulse;
      while (npulse == k) step();
   endtask

   task automatic svc(input logic [7:0] b);
      svc_we = 1'b1; svc_data = b;
      step();
      svc_we = 1'b0; svc_data = 8'h00;
   endtask

   task automatic ctl(input logic p, input logic [1:0] t);
      ctl_we = 1'b1; ctl_prescale = p; ctl_tsel = t;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic key_pair();
      svc(8'h55);
      svc(8'hAA);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int d;
      // R1: reset state with strap high (prescaler off)
      cur_req = "R1";
      mode_strap = 1'b1; rst_n = 1'b0;
      step(); step();
      check(rst_req == 1'b0, "R1 in reset", int'(rst_req), 0);
      rst_n = 1'b1;
      step();
      check(rst_req == 1'b0, "R1 after reset", int'(rst_req), 0);

      // R5 / R12: select 0 period, one-cycle pulse
      cur_req = "R5";
      wd_enable = 1'b1;
      wait_pulse(); wait_pulse();
      check(p_last - p_prev == 16, "R5 select0 gap", p_last - p_prev, 16);
      step();
      check(rst_req == 1'b0, "R12 pulse one cycle", int'(rst_req), 0);

      // R3: key pair with idle cycles between
      cur_req = "R3";
      wait_pulse();
      svc(8'h55); repeat (5) step(); svc(8'hAA);
      d = cyc; wait_pulse();
      check(p_last - d == 16, "R3 restart", p_last - d, 16);

      // R4: lone closing key ignored
      cur_req = "R4";
      wait_pulse(); repeat (3) step(); svc(8'hAA);
      wait_pulse();
      check(p_last - p_prev == 16, "R4 lone 0xAA ignored", p_last - p_prev, 16);
      // R4: other value drops the pending opening key
      wait_pulse(); svc(8'h55); svc(8'h12); svc(8'hAA);
      wait_pulse();
      check(p_last - p_prev == 16, "R4 other value disarms", p_last - p_prev, 16);

      // R7: select shadowed until restart
      cur_req = "R7";
      wait_pulse(); ctl(1'b0, 2'd1);
      wait_pulse();
      check(p_last - p_prev == 16, "R7 select not yet active", p_last - p_prev, 16);
      wait_pulse(); key_pair(); d = cyc;
      wait_pulse();
      check(p_last - d == 64, "R7 select active after service", p_last - d, 64);
      cur_req = "R5";
      wait_pulse();
      check(p_last - p_prev == 64, "R5 select1 gap", p_last - p_prev, 64);
      ctl(1'b0, 2'd3); key_pair(); d = cyc;
      wait_pulse();
      check(p_last - d == 1024, "R5 select3 period", p_last - d, 1024);
      ctl(1'b0, 2'd0); key_pair();

      // R10: tick gating
      cur_req = "R10";
      wait_pulse();
      tick = 1'b0; repeat (10) step(); tick = 1'b1;
      wait_pulse();
      check(p_last - p_prev == 26, "R10 tick pause", p_last - p_prev, 26);

      // R8: low-power stop holds the count
      cur_req = "R8";
      wait_pulse();
      lp_stop = 1'b1; repeat (7) step(); lp_stop = 1'b0;
      wait_pulse();
      check(p_last - p_prev == 23, "R8 stop hold", p_last - p_prev, 23);

      // R9: freeze alone no effect; with stop bit it halts
      cur_req = "R9";
      freeze = 1'b1;
      wait_pulse(); wait_pulse();
      check(p_last - p_prev == 16, "R9 freeze without bit", p_last - p_prev, 16);
      frz_stop_en = 1'b1; repeat (5) step(); frz_stop_en = 1'b0;
      wait_pulse();
      check(p_last - p_prev == 21, "R9 freeze with bit", p_last - p_prev, 21);
      freeze = 1'b0;

      // R6: prescaler multiplies by 8 in this bench
      cur_req = "R6";
      ctl(1'b1, 2'd0); key_pair(); d = cyc;
      wait_pulse();
      check(p_last - d == 128, "R6 prescaled period", p_last - d, 128);
      wait_pulse();
      check(p_last - p_prev == 128, "R6 prescaled gap", p_last - p_prev, 128);

      // R11: disabled block is quiet, full period after re-enable
      cur_req = "R11";
      wd_enable = 1'b0; d = npulse;
      repeat (300) step();
      check(npulse == d, "R11 no pulse while disabled", npulse - d, 0);
      wd_enable = 1'b1; d = cyc;
      wait_pulse();
      check(p_last - d == 128, "R11 period after re-enable", p_last - d, 128);

      // R2: strap low gives prescaler on; software can clear it
      cur_req = "R2";
      rst_n = 1'b0; mode_strap = 1'b0;
      step(); step();
      check(rst_req == 1'b0, "R1 in second reset", int'(rst_req), 0);
      rst_n = 1'b1; d = cyc;
      wait_pulse();
      check(p_last - d == 128, "R2 strap low prescaler on", p_last - d, 128);
      ctl(1'b0, 2'd0); key_pair(); d = cyc;
      wait_pulse();
      check(p_last - d == 16, "R2 prescaler cleared by write", p_last - d, 16);

      repeat (4) step();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule